// File: doc/BRIEF.md
# Saturating two-digit decimal counter

This block counts clock edges in decimal on two digits, a ones digit and a tens digit. It starts at 00 and climbs one step per enabled clock edge. When the ones digit would pass 9 it returns to 0, and on that same edge the tens digit moves up by one. Once the tens digit reaches 8 the counter stops advancing and shows 80 until it is reset.

A synchronous, active-high reset clears both digits on the next rising edge. Reset wins over counting and over the held state. A count-enable input freezes both digits while it is low, without clearing them.

Each digit is available as a 4-bit BCD value. Each digit is also decoded into an active-low seven-segment pattern for its own display. A flag reports when the count is held at 80. The block has no data stream, so every pin is a plain control or status signal.

Top module: `sat_dec_counter`

## Requirements
- R1: When `rst` is high at a rising edge, both digits become 0 after that edge, whatever `en` is and whether or not the count is held at 80.
- R2: When `rst` is low, `en` is high, the count is below 80 and the ones digit is below 9, a rising edge adds one to the ones digit.
- R3: When `rst` is low, `en` is high, the count is below 80 and the ones digit is 9, a rising edge sets the ones digit to 0 and adds one to the tens digit on that same edge.
- R4: The tens digit changes only on the edge described in R3 or on reset.
- R5: Once the count is 80, no edge with `rst` low changes either digit, whatever `en` is.
- R6: When `rst` and `en` are both low, a rising edge leaves both digits unchanged.
- R7: `saturated` is 1 exactly when the count is 80, and 0 otherwise.
- R8: Each `*_seg_n` output shows its digit as an active-low pattern with bit 6 down to bit 0 = segments g,f,e,d,c,b,a. The patterns for digits 0 to 9 are 0x40, 0x79, 0x24, 0x30, 0x19, 0x12, 0x02, 0x78, 0x00 and 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of both digits |
| en | input | 1 | Count enable; low freezes both digits |
| ones_bcd | output | 4 | Ones digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| ones_seg_n | output | 7 | Ones digit, active-low segments gfedcba |
| tens_seg_n | output | 7 | Tens digit, active-low segments gfedcba |
| saturated | output | 1 | High while the count is held at 80 |

## Verification
The bench builds the block with its default limits: the ones digit returns to 0 after 9 and the count stops at a tens digit of 8. With these limits every digit glyph from 0 to 9 appears on the ones display. Every tens value up to 8 appears on the tens display, and saturation is reached within about a hundred cycles. Each vector is therefore run against the real stop point, with no shortened count. This lets the bench cover reset taking priority over the held state. It also covers enable toggling across several ones-to-tens carries, and re-counting after a reset both from 80 and from partway through a count.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-low glyphs, bit order g f e d c b a; non-decimal codes are blank.
  function automatic seg_t bcd_to_seg_n(bcd_t d);
    seg_t lit;
    case (d)
      4'd0:    lit = 7'b0111111;
      4'd1:    lit = 7'b0000110;
      4'd2:    lit = 7'b1011011;
      4'd3:    lit = 7'b1001111;
      4'd4:    lit = 7'b1100110;
      4'd5:    lit = 7'b1101101;
      4'd6:    lit = 7'b1111101;
      4'd7:    lit = 7'b0000111;
      4'd8:    lit = 7'b1111111;
      4'd9:    lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
    return ~lit;
  endfunction
endpackage

// File: rtl/sdc_digit.sv
module sdc_digit #(
  parameter int W    = 4,
  parameter int LAST = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic at_last;
  assign at_last = (q == LAST_V);
  assign wrap    = step && at_last;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (wrap) q <= '0;
    else if (step) q <= q + 1'b1;
  end

  // R2
  dig_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !at_last) |=> (q == W'($past(q) + 1'b1)));

  // R3
  dig_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> (q == '0));

  // R6
  dig_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(q));
endmodule

// File: rtl/sdc_seg7.sv
module sdc_seg7
  import sdc_pkg::*;
(
  input  bcd_t bcd,
  output seg_t seg_n
);
  assign seg_n = bcd_to_seg_n(bcd);

  // R8: every decimal glyph lights at least two segments
  always_comb begin
    if (bcd <= 4'd9) begin
      seg_lit_chk: assert ($countones(~seg_n) >= 2);
    end
  end
endmodule

// File: rtl/sat_dec_counter.sv
module sat_dec_counter
  import sdc_pkg::*;
#(
  parameter int ONES_LAST = 9,
  parameter int TENS_STOP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [BCD_W-1:0] ones_bcd,
  output logic [BCD_W-1:0] tens_bcd,
  output logic [SEG_W-1:0] ones_seg_n,
  output logic [SEG_W-1:0] tens_seg_n,
  output logic             saturated
);
  localparam int         N_DIG  = 2;
  localparam logic [BCD_W-1:0] STOP_V = BCD_W'(TENS_STOP);

  logic ones_step, ones_wrap, tens_wrap, hold;
  bcd_t digit [N_DIG];
  seg_t seg   [N_DIG];

  assign hold      = (tens_bcd == STOP_V);
  assign ones_step = en && !hold;

  sdc_digit #(.W(BCD_W), .LAST(ONES_LAST)) i_ones (
    .clk(clk), .rst(rst), .step(ones_step), .q(ones_bcd), .wrap(ones_wrap)
  );

  sdc_digit #(.W(BCD_W), .LAST(9)) i_tens (
    .clk(clk), .rst(rst), .step(ones_wrap), .q(tens_bcd), .wrap(tens_wrap)
  );

  assign digit[0] = ones_bcd;
  assign digit[1] = tens_bcd;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dec
    sdc_seg7 i_seg (.bcd(digit[g]), .seg_n(seg[g]));
  end

  assign ones_seg_n = seg[0];
  assign tens_seg_n = seg[1];
  assign saturated  = hold;

  // R1
  clear_chk: assert property (@(posedge clk)
    rst |=> (ones_bcd == '0 && tens_bcd == '0));

  // R3
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    ones_wrap |=> (ones_bcd == '0 && tens_bcd == BCD_W'($past(tens_bcd) + 1'b1)));

  // R4
  tens_still_chk: assert property (@(posedge clk) disable iff (rst)
    !ones_wrap |=> $stable(tens_bcd));

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    saturated |=> ($stable(ones_bcd) && $stable(tens_bcd)));

  // R7
  sat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    saturated |-> (ones_bcd == '0));

  // R4: the tens digit never reaches its own wrap point
  no_tens_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !tens_wrap);
endmodule

// File: tb/test_sat_dec_counter.sv
`timescale 1ns/1ps
module test_sat_dec_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [3:0] ones_bcd, tens_bcd;
  logic [6:0] ones_seg_n, tens_seg_n;
  logic saturated;

  always #2 clk = ~clk;

  sat_dec_counter i_sat_dec_counter (
    .clk(clk), .rst(rst), .en(en),
    .ones_bcd(ones_bcd), .tens_bcd(tens_bcd),
    .ones_seg_n(ones_seg_n), .tens_seg_n(tens_seg_n),
    .saturated(saturated)
  );

  int n_vec = 0;
  int n_bad = 0;
  int m_ones = 0;
  int m_tens = 0;
  int qo[$];
  int qt[$];
  string qtag[$];

  function automatic logic [6:0] glyph_n(int d);
    case (d)
      0: return 7'h40;
      1: return 7'h79;
      2: return 7'h24;
      3: return 7'h30;
      4: return 7'h19;
      5: return 7'h12;
      6: return 7'h02;
      7: return 7'h78;
      8: return 7'h00;
      9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic apply(input logic r, input logic e);
    string tag;
    @(negedge clk);
    rst = r;
    en  = e;
    if (r) begin
      tag = "R1"; m_ones = 0; m_tens = 0;
    end else if (m_tens == 8) begin
      tag = "R5";
    end else if (!e) begin
      tag = "R6";
    end else if (m_ones == 9) begin
      tag = "R3"; m_ones = 0; m_tens++;
    end else begin
      tag = "R2,R4"; m_ones++;
    end
    qo.push_back(m_ones);
    qt.push_back(m_tens);
    qtag.push_back(tag);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin : monitor
    int eo, et;
    string tg;
    forever begin
      @(posedge clk);
      #1;
      if (qo.size() > 0) begin
        eo = qo.pop_front();
        et = qt.pop_front();
        tg = qtag.pop_front();
        n_vec++;
        if (ones_bcd !== 4'(eo)) begin
          n_bad++; $display("FAIL %s ones_bcd actual %0d expected %0d", tg, ones_bcd, eo);
        end
        if (tens_bcd !== 4'(et)) begin
          n_bad++; $display("FAIL %s tens_bcd actual %0d expected %0d", tg, tens_bcd, et);
        end
        if (ones_seg_n !== glyph_n(eo)) begin
          n_bad++; $display("FAIL R8 ones_seg_n actual %h expected %h", ones_seg_n, glyph_n(eo));
        end
        if (tens_seg_n !== glyph_n(et)) begin
          n_bad++; $display("FAIL R8 tens_seg_n actual %h expected %h", tens_seg_n, glyph_n(et));
        end
        if (saturated !== (eo == 0 && et == 8)) begin
          n_bad++; $display("FAIL R7 saturated actual %b expected %b", saturated, (eo == 0 && et == 8));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual running expected done");
    report();
    $finish;
  end

  initial begin : driver
    // R1: reset state
    apply(1'b1, 1'b0);
    apply(1'b1, 1'b1);
    // R2, R3: plain counting across two carries
    for (int i = 0; i < 25; i++) apply(1'b0, 1'b1);
    // R6: freeze with enable low
    for (int i = 0; i < 5; i++) apply(1'b0, 1'b0);
    // R2, R3, R6: toggling enable across carries
    for (int i = 0; i < 30; i++) apply(1'b0, 1'(i % 2));
    for (int i = 0; i < 6; i++) apply(1'b0, 1'(i % 3 == 0));
    // R5: run up to 80 and beyond
    for (int i = 0; i < 70; i++) apply(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) apply(1'b0, 1'(i % 2));
    // R1: reset overrides the held state, with enable high
    apply(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) apply(1'b0, 1'b1);
    // R1: reset with enable low, mid count
    apply(1'b1, 1'b0);
    for (int i = 0; i < 15; i++) apply(1'b0, 1'b1);
    @(negedge clk);
    @(negedge clk);
    report();
    $finish;
  end
endmodule